// File: doc/BRIEF.md
# ZQ Calibration Quiet-Window Monitor

This block observes the command pins of a DDR3 channel, one decoded command per clock. When it sees a ZQ calibration command it opens a quiet window. The window lasts a programmed number of clocks, and that number depends on the kind of calibration. Any command other than a no-operation or a deselect that lands inside the open window is a protocol breach. The monitor reports each breach with a one-cycle strobe. The strobe carries the command code of the offender and how many clocks had passed since the calibration started.

Three window lengths are programmed: one for the first long calibration after reset, one for every later long calibration, and one for short calibrations. A calibration that arrives while a window is still open counts as a breach. It also starts a new window of its own kind.

A separate qualifier output is high for every cycle that held a calibration command or a breach. It lets a trace store downstream keep only the events of interest.

Top module: `zq_quiet_monitor`

## Requirements
- R1: A ZQ command is cs_n=0, ras_n=1, cas_n=1, we_n=0 in one cycle. a10=1 makes it a long calibration and a10=0 a short one.
- R2: The first long calibration after reset opens a window of ZQ_INIT_CLKS clocks. A non-idle command e clocks after it (e=1 is the next cycle) is a breach when 1 <= e < ZQ_INIT_CLKS, and is legal when e >= ZQ_INIT_CLKS.
- R3: Every later long calibration opens a window of ZQ_OPER_CLKS clocks, with the same breach rule.
- R4: A short calibration opens a window of ZQ_SHORT_CLKS clocks with the same rule. It does not count as the first long calibration.
- R5: A deselect (cs_n=1) or a NOP (cs_n=0, ras_n=cas_n=we_n=1) is never a breach, whether or not a window is open.
- R6: A breach raises viol for exactly the cycle after the offending command. In that cycle viol_cmd equals {ras_n,cas_n,we_n} of the offender, and viol_elapsed equals e. Both fields are zero when viol is low.
- R7: A ZQ command inside an open window is reported as a breach with code 3'b110. A new window of that command's own kind and length then starts from it.
- R8: qual is high in the cycle after any ZQ command or any breach, and low otherwise.
- R9: While rst_n is low at a clock edge, viol, viol_cmd, viol_elapsed and qual are zero after that edge. After reset no window is open, and the next long calibration counts as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit 10, picks long or short calibration |
| viol | output | 1 | One-cycle breach strobe |
| viol_cmd | output | 3 | {ras_n,cas_n,we_n} of the offending command |
| viol_elapsed | output | CNT_W | Clocks from calibration to the offending command |
| qual | output | 1 | Storage qualifier: calibration or breach cycle |

## Verification
Two functions can fall in the same cycle. A calibration command can both close out the current window as a breach and open a fresh window. The bench provokes this by sending a long calibration two clocks after a short one. It then checks three things: the breach carries code 3'b110 and elapsed 2, qual is high, and the restarted window uses the initial long length. To judge the last point it probes just inside that length, and it probes once more after the window has drained.

// File: rtl/zqm_pkg.sv
// Shared types and helpers for the ZQ quiet-window monitor.
// Assumes: the durations are positive integers that fit in 32 bits.
package zqm_pkg;

    typedef enum logic [1:0] {
        ZQK_NONE  = 2'd0,
        ZQK_SHORT = 2'd1,
        ZQK_LONG  = 2'd2
    } zq_kind_e;

    // Width needed to hold the largest of three durations.
    function automatic int cnt_width(input int d0, input int d1, input int d2);
        int m;
        m = d0;
        if (d1 > m) m = d1;
        if (d2 > m) m = d2;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/zqm_decode.sv
// Command classifier. It sorts the pins of one cycle into idle
// (deselect or NOP), a ZQ calibration of a given kind, or something else.
// Assumes: the pins have already been sampled on the command clock.
module zqm_decode
    import zqm_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     a10,
    output logic     is_idle,
    output zq_kind_e zq_kind,
    output logic [2:0] cmd_code
);

    // Classify the command present on the pins this cycle.
    always_comb begin
        is_idle  = cs_n | (ras_n & cas_n & we_n);
        cmd_code = {ras_n, cas_n, we_n};
        zq_kind  = ZQK_NONE;
        if (!cs_n && ras_n && cas_n && !we_n)
            zq_kind = a10 ? ZQK_LONG : ZQK_SHORT;
    end

endmodule

// File: rtl/zqm_window.sv
// Quiet-window tracker. A ZQ command loads a length that depends on its
// kind and opens the window. elapsed then counts the clocks since that
// command, and the window closes once elapsed reaches the length.
// Assumes: every duration is at least 2 and fits in CNT_W bits.
module zqm_window
    import zqm_pkg::*;
#(
    parameter int ZQ_INIT_CLKS  = 512,
    parameter int ZQ_OPER_CLKS  = 256,
    parameter int ZQ_SHORT_CLKS = 64,
    parameter int CNT_W         = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  zq_kind_e         zq_kind,
    output logic             win_open,
    output logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] LEN_INIT  = CNT_W'(ZQ_INIT_CLKS);
    localparam logic [CNT_W-1:0] LEN_OPER  = CNT_W'(ZQ_OPER_CLKS);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(ZQ_SHORT_CLKS);

    logic             long_seen;
    logic [CNT_W-1:0] win_len;
    logic [CNT_W-1:0] next_len;

    // Pick the length of the window a calibration this cycle would open.
    always_comb begin
        next_len = LEN_SHORT;
        if (zq_kind == ZQK_LONG)
            next_len = long_seen ? LEN_OPER : LEN_INIT;
    end

    // Open, advance and close the window; remember whether a long calibration has happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open  <= 1'b0;
            elapsed   <= '0;
            win_len   <= '0;
            long_seen <= 1'b0;
        end else if (zq_kind != ZQK_NONE) begin
            win_open <= 1'b1;
            elapsed  <= CNT_W'(1);
            win_len  <= next_len;
            if (zq_kind == ZQK_LONG)
                long_seen <= 1'b1;
        end else if (win_open) begin
            if (elapsed == win_len - 1'b1) begin
                win_open <= 1'b0;
                elapsed  <= '0;
            end else begin
                elapsed <= elapsed + 1'b1;
            end
        end
    end

endmodule

// File: rtl/zqm_report.sv
// Breach reporter. It flags a non-idle command inside an open window and
// registers the strobe, the code, the elapsed count and the storage qualifier.
// Assumes: win_open and elapsed describe the current cycle's command.
module zqm_report #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_open,
    input  logic [CNT_W-1:0] elapsed,
    input  logic             is_idle,
    input  logic             is_zq,
    input  logic [2:0]       cmd_code,
    output logic             viol,
    output logic [2:0]       viol_cmd,
    output logic [CNT_W-1:0] viol_elapsed,
    output logic             qual
);

    logic breach;

    // A breach is any non-idle command while the window is open.
    always_comb breach = win_open & ~is_idle;

    // Register the report fields, zeroed when there is no breach.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol         <= 1'b0;
            viol_cmd     <= '0;
            viol_elapsed <= '0;
            qual         <= 1'b0;
        end else begin
            viol         <= breach;
            viol_cmd     <= breach ? cmd_code : 3'b000;
            viol_elapsed <= breach ? elapsed : '0;
            qual         <= breach | is_zq;
        end
    end

endmodule

// File: rtl/zq_quiet_monitor.sv
// Top of the ZQ quiet-window monitor. It chains the decoder, the window
// tracker and the reporter.
// Assumes: one command per clock on the pins, synchronous active-low reset.
module zq_quiet_monitor
    import zqm_pkg::*;
#(
    parameter int ZQ_INIT_CLKS  = 512,
    parameter int ZQ_OPER_CLKS  = 256,
    parameter int ZQ_SHORT_CLKS = 64,
    parameter int CNT_W         = cnt_width(ZQ_INIT_CLKS, ZQ_OPER_CLKS, ZQ_SHORT_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             a10,
    output logic             viol,
    output logic [2:0]       viol_cmd,
    output logic [CNT_W-1:0] viol_elapsed,
    output logic             qual
);

    logic             is_idle;
    zq_kind_e         zq_kind;
    logic [2:0]       cmd_code;
    logic             win_open;
    logic [CNT_W-1:0] elapsed;

    zqm_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (a10),
        .is_idle  (is_idle),
        .zq_kind  (zq_kind),
        .cmd_code (cmd_code)
    );

    zqm_window #(
        .ZQ_INIT_CLKS  (ZQ_INIT_CLKS),
        .ZQ_OPER_CLKS  (ZQ_OPER_CLKS),
        .ZQ_SHORT_CLKS (ZQ_SHORT_CLKS),
        .CNT_W         (CNT_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .zq_kind  (zq_kind),
        .win_open (win_open),
        .elapsed  (elapsed)
    );

    zqm_report #(
        .CNT_W (CNT_W)
    ) u_rep (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_open     (win_open),
        .elapsed      (elapsed),
        .is_idle      (is_idle),
        .is_zq        (zq_kind != ZQK_NONE),
        .cmd_code     (cmd_code),
        .viol         (viol),
        .viol_cmd     (viol_cmd),
        .viol_elapsed (viol_elapsed),
        .qual         (qual)
    );

endmodule

// File: rtl/zqm_checker.sv
// Property checker for zq_quiet_monitor, attached with bind.
// Assumes: the same durations as the monitor it is bound to.
module zqm_checker #(
    parameter int ZQ_INIT_CLKS  = 512,
    parameter int ZQ_OPER_CLKS  = 256,
    parameter int ZQ_SHORT_CLKS = 64,
    parameter int CNT_W         = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             viol,
    input logic [2:0]       viol_cmd,
    input logic [CNT_W-1:0] viol_elapsed,
    input logic             qual
);

    localparam int MAX_LEN = (ZQ_INIT_CLKS > ZQ_OPER_CLKS)
        ? ((ZQ_INIT_CLKS > ZQ_SHORT_CLKS) ? ZQ_INIT_CLKS : ZQ_SHORT_CLKS)
        : ((ZQ_OPER_CLKS > ZQ_SHORT_CLKS) ? ZQ_OPER_CLKS : ZQ_SHORT_CLKS);

    AST_IDLE_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (ras_n && cas_n && we_n)) |=> !viol); // R5

    AST_ZQ_RAISES_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && cas_n && !we_n) |=> qual); // R8

    AST_BREACH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> qual); // R8

    AST_CODE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_cmd == $past({ras_n, cas_n, we_n}))); // R6

    AST_ELAPSED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_elapsed != '0 && int'(viol_elapsed) < MAX_LEN)); // R6

    AST_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !viol |-> (viol_cmd == 3'b000 && viol_elapsed == '0)); // R6

endmodule

bind zq_quiet_monitor zqm_checker #(
    .ZQ_INIT_CLKS  (ZQ_INIT_CLKS),
    .ZQ_OPER_CLKS  (ZQ_OPER_CLKS),
    .ZQ_SHORT_CLKS (ZQ_SHORT_CLKS),
    .CNT_W         (CNT_W)
) u_chk (.*);

// File: tb/sim_zq_quiet_monitor.sv
// Bench: sweeps the probe distance across all three window kinds in a small
// configuration and works out every expected result from the requirements.
module sim_zq_quiet_monitor;

    localparam int D_INIT  = 12;
    localparam int D_OPER  = 8;
    localparam int D_SHORT = 5;
    localparam int CW      = 8;
    localparam int SWEEP   = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic          viol;
    logic [2:0]    viol_cmd;
    logic [CW-1:0] viol_elapsed;
    logic          qual;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    bit flip  = 1'b0;

    always #2 clk = ~clk;

    zq_quiet_monitor #(
        .ZQ_INIT_CLKS  (D_INIT),
        .ZQ_OPER_CLKS  (D_OPER),
        .ZQ_SHORT_CLKS (D_SHORT),
        .CNT_W         (CW)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .a10          (a10),
        .viol         (viol),
        .viol_cmd     (viol_cmd),
        .viol_elapsed (viol_elapsed),
        .qual         (qual)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one command at the falling edge; sample just after the next rising edge.
    task automatic step(input logic c, input logic r, input logic ca, input logic w, input logic a);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; a10 = a;
        @(posedge clk);
        #1;
    endtask

    // Idle cycle, alternating NOP and deselect; no report may appear (R5, R8).
    task automatic idle_step(input string req);
        flip = ~flip;
        if (flip) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        else      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        chk({req, " R5"}, "viol on idle", int'(viol), 0);
        chk({req, " R8"}, "qual on idle", int'(qual), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; a10 = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R9", "viol in reset", int'(viol), 0);
        chk("R9", "cmd in reset", int'(viol_cmd), 0);
        chk("R9", "elapsed in reset", int'(viol_elapsed), 0);
        chk("R9", "qual in reset", int'(qual), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // A ZQ from a closed window: no breach, qualifier high (R1, R8).
    task automatic zq_clean(input logic is_long, input string req);
        step(1'b0, 1'b1, 1'b1, 1'b0, is_long);
        chk({req, " R1"}, "viol on clean zq", int'(viol), 0);
        chk({req, " R8"}, "qual on zq", int'(qual), 1);
    endtask

    // Send an ACTIVATE (code 3'b011) at distance e and judge it against length d.
    task automatic probe(input int e, input int d, input string req);
        for (int k = 1; k < e; k++) idle_step(req);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk({req, " R6"}, "viol", int'(viol), (e < d) ? 1 : 0);
        chk({req, " R6"}, "cmd", int'(viol_cmd), (e < d) ? 3 : 0);
        chk({req, " R6"}, "elapsed", int'(viol_elapsed), (e < d) ? e : 0);
        chk({req, " R8"}, "qual", int'(qual), (e < d) ? 1 : 0);
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < D_INIT + 2; k++) idle_step(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        do_reset();

        // Sweep the probe distance across every window kind (R2, R3, R4).
        for (int e = 1; e <= SWEEP; e++) begin
            do_reset();
            zq_clean(1'b1, "R2");
            probe(e, D_INIT, "R2");
            drain("R2");
            zq_clean(1'b1, "R3");
            probe(e, D_OPER, "R3");
            drain("R3");
            zq_clean(1'b0, "R4");
            probe(e, D_SHORT, "R4");
            drain("R4");
        end

        // ZQ inside an open window: breach, then a restarted window (R7, R4).
        do_reset();
        zq_clean(1'b0, "R7");
        idle_step("R7");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R7", "viol on nested zq", int'(viol), 1);
        chk("R7", "nested zq code", int'(viol_cmd), 6);
        chk("R7", "nested zq elapsed", int'(viol_elapsed), 2);
        chk("R7 R8", "qual on nested zq", int'(qual), 1);
        probe(D_INIT - 1, D_INIT, "R7 R4");
        drain("R7");
        probe(1, 0, "R7");

        // A second nested ZQ, short inside long, restarts with the short length (R7).
        do_reset();
        zq_clean(1'b1, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R7", "short nested viol", int'(viol), 1);
        chk("R7", "short nested elapsed", int'(viol_elapsed), 1);
        probe(D_SHORT, D_SHORT, "R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule